// File: doc/BRIEF.md
# Interpolating DAC Sample Sequencer

This block drives the code input of a 12-bit digital-to-analog converter. It can hold one programmed level. It can also play stored samples, either for a fixed count or without end. Samples are written into a small FIFO. During playback they are taken out at a pace set by a programmable clock divider, so the output continues without gaps while software refills the FIFO.

An optional linear interpolator turns each stored sample into 2, 4 or 8 output steps. These steps ramp evenly from the code that was on the output to the new sample. The arithmetic uses only a signed difference, shifts and an add.

Each new output code comes with a one-cycle update strobe. Two sticky flags report state: one marks a finished burst, the other marks that a sample was due while the FIFO was empty.

Top module: `dac_seq`

## Requirements
- R1: After reset, `dac_code` is 0, `dac_update`, `done` and `underrun` are 0, `fifo_level` is 0 and `fifo_empty` is 1.
- R2: With `mode` 0 (static; the value 3 behaves the same), `dac_code` takes `static_code` one clock later. `dac_update` pulses only in the cycle the code changes. `run` has no effect in this mode.
- R3: A write is stored when `wr_en` is high and the FIFO is not full. A write to a full FIFO is dropped. `fifo_level` counts the stored samples (8 at the default depth), `fifo_full` is set at the depth, and `fifo_empty` is set at zero.
- R4: During playback, one output step with a `dac_update` pulse is produced every `rate_div`+1 clocks. `dac_code` never changes without `dac_update`.
- R5: With `interp_sel` 0, each step outputs the next FIFO sample, in the order the samples were written.
- R6: `interp_sel` 1, 2 or 3 selects R = 2, 4 or 8. Each sample then yields R steps. Step k (1..R) is p + floor((s - p)·k / R), where p is the code before the sample's first step and s is the sample. Step R therefore equals s.
- R7: With `mode` 1 (burst), `done` is set once `burst_len` (at least 1) samples have been fully output. After that there are no further updates and the last code is held.
- R8: With `mode` 2 (continuous), playback goes on as long as data arrive, and `done` is never set.
- R9: If the FIFO is empty when a new sample is due, the code is held, no update is given and `underrun` is set. `underrun` stays set until the next playback start. Playback resumes once data arrive.
- R10: Playback runs only while `run` is high. A rising `run` clears `done`, `underrun`, the sample count and the step phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Sample write strobe |
| wr_data | input | 12 | Sample to store |
| mode | input | 2 | 0 static, 1 burst, 2 continuous, 3 static |
| static_code | input | 12 | Level held in static mode |
| run | input | 1 | Playback enable; rising edge starts a new run |
| burst_len | input | 16 | Number of samples in a burst |
| rate_div | input | 16 | Clocks per output step minus one |
| interp_sel | input | 2 | 0 none, 1 2:1, 2 4:1, 3 8:1 |
| dac_code | output | 12 | Code to the converter |
| dac_update | output | 1 | One-cycle pulse with each new code |
| fifo_level | output | 4 | Samples stored |
| fifo_empty | output | 1 | FIFO holds no sample |
| fifo_full | output | 1 | FIFO is at depth |
| underrun | output | 1 | Sticky: sample due with FIFO empty |
| done | output | 1 | Sticky: burst complete |

## Verification
The bench fills the FIFO past its depth and plays an unscaled burst. This shows whether samples come out in write order, whether the extra write is dropped, and whether steps keep the divider spacing. Interpolated bursts at 4:1 use rising, falling and full-scale samples, so the floor rounding of negative differences is separated from truncation toward zero. A continuous run at 8:1 drains the FIFO to show the hold and sticky underrun, and then resumes. A 2:1 burst restarted with no data shows that a rising `run` clears the flags.

// File: rtl/dac_seq_pkg.sv
// Shared encodings for the DAC sample sequencer.
// Assumes: mode is a 2-bit control; code 3 is treated as static.
package dac_seq_pkg;
    typedef enum logic [1:0] {
        MODE_STATIC = 2'd0,
        MODE_BURST  = 2'd1,
        MODE_CONT   = 2'd2,
        MODE_SPARE  = 2'd3
    } seq_mode_e;
endpackage

// File: rtl/dac_fifo.sv
// Sample store: synchronous FIFO with show-ahead read data.
// Assumes: pops arrive only as a single strobe; writes when full are dropped.
module dac_fifo #(
    parameter int W     = 12,
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [LW-1:0] level,
    output logic          empty,
    output logic          full
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    assign empty   = (level == '0);
    assign full    = (level == LW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rptr];

    // Storage write, no reset needed for data.
    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= push_data;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (do_push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            if (do_push && !do_pop)      level <= level + 1'b1;
            else if (do_pop && !do_push) level <= level - 1'b1;
        end
    end
endmodule

// File: rtl/dac_rate_tick.sv
// Step pacing: one tick every div+1 enabled clocks.
// Assumes: clear restarts the count; disabled cycles hold the count at zero.
module dac_rate_tick #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          enable,
    input  logic [DW-1:0] div,
    output logic          tick
);
    logic [DW-1:0] cnt;

    assign tick = enable && !clear && (cnt >= div);

    // Divider count.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt <= '0;
        else if (clear || !enable)  cnt <= '0;
        else if (tick)              cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/dac_interp.sv
// Linear step generator: base + floor((target-base)*k / 2^shift).
// Assumes: k <= 2^shift <= 8, so the result lies between base and target.
module dac_interp #(
    parameter int W = 12
) (
    input  logic [W-1:0] base,
    input  logic [W-1:0] target,
    input  logic [3:0]   k,
    input  logic [1:0]   shift,
    output logic [W-1:0] value
);
    localparam int DW = W + 1;
    localparam int PW = DW + 4;

    logic signed [DW-1:0] diff;
    logic signed [PW-1:0] dext, acc, scaled, total;
    logic signed [PW-1:0] term [4];

    assign diff = $signed({1'b0, target}) - $signed({1'b0, base});
    assign dext = {{(PW - DW){diff[DW-1]}}, diff};

    // Partial products for k, built from shifts.
    for (genvar b = 0; b < 4; b++) begin : g_term
        assign term[b] = k[b] ? (dext <<< b) : '0;
    end

    // Sum, divide by the ratio with an arithmetic shift, add the base.
    always_comb begin
        acc    = term[0] + term[1] + term[2] + term[3];
        scaled = acc >>> shift;
        total  = $signed({{(PW - W){1'b0}}, base}) + scaled;
        value  = total[W-1:0];
    end
endmodule

// File: rtl/dac_seq.sv
// DAC sample sequencer top: static, burst and continuous playback with
// optional 2/4/8:1 linear interpolation. Assumes burst_len >= 1 in burst
// mode and that mode is changed while run is low.
module dac_seq
    import dac_seq_pkg::*;
#(
    parameter int W     = 12,
    parameter int DEPTH = 8,
    parameter int CW    = 16,
    parameter int DW    = 16,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic [1:0]    mode,
    input  logic [W-1:0]  static_code,
    input  logic          run,
    input  logic [CW-1:0] burst_len,
    input  logic [DW-1:0] rate_div,
    input  logic [1:0]    interp_sel,
    output logic [W-1:0]  dac_code,
    output logic          dac_update,
    output logic [LW-1:0] fifo_level,
    output logic          fifo_empty,
    output logic          fifo_full,
    output logic          underrun,
    output logic          done
);
    seq_mode_e     mode_e;
    logic          play_mode, run_q, run_start, active, tick;
    logic          due, pop, step_go, final_step;
    logic [W-1:0]  fifo_head, code_q, base_q, next_q, base_sel, target_sel, step_val;
    logic [2:0]    phase, last_phase;
    logic [3:0]    k;
    logic [CW-1:0] samp_cnt, cnt_eff;

    assign mode_e    = seq_mode_e'(mode);
    assign play_mode = (mode_e == MODE_BURST) || (mode_e == MODE_CONT);
    assign run_start = run && !run_q;
    assign active    = run && play_mode && !done;

    // Ratio selection: last phase index of a sample's step group.
    always_comb begin
        case (interp_sel)
            2'd1:    last_phase = 3'd1;
            2'd2:    last_phase = 3'd3;
            2'd3:    last_phase = 3'd7;
            default: last_phase = 3'd0;
        endcase
    end

    assign due        = tick && (phase == 3'd0);
    assign pop        = due && !fifo_empty;
    assign step_go    = pop || (tick && (phase != 3'd0));
    assign final_step = step_go && (phase >= last_phase);
    assign k          = {1'b0, phase} + 4'd1;
    assign base_sel   = (phase == 3'd0) ? code_q : base_q;
    assign target_sel = (phase == 3'd0) ? fifo_head : next_q;
    assign cnt_eff    = pop ? samp_cnt + 1'b1 : samp_cnt;

    dac_fifo #(.W(W), .DEPTH(DEPTH)) fifo_i (
        .clk(clk), .rst_n(rst_n), .push(wr_en), .push_data(wr_data),
        .pop(pop), .head(fifo_head), .level(fifo_level),
        .empty(fifo_empty), .full(fifo_full)
    );

    dac_rate_tick #(.DW(DW)) tick_i (
        .clk(clk), .rst_n(rst_n), .clear(run_start), .enable(active),
        .div(rate_div), .tick(tick)
    );

    dac_interp #(.W(W)) interp_i (
        .base(base_sel), .target(target_sel), .k(k), .shift(interp_sel),
        .value(step_val)
    );

    // Output code, step phase, burst count and sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q      <= 1'b0;
            code_q     <= '0;
            base_q     <= '0;
            next_q     <= '0;
            phase      <= '0;
            samp_cnt   <= '0;
            dac_update <= 1'b0;
            underrun   <= 1'b0;
            done       <= 1'b0;
        end else begin
            run_q      <= run;
            dac_update <= 1'b0;
            if (!play_mode) begin
                code_q     <= static_code;
                dac_update <= (static_code != code_q);
                phase      <= '0;
            end else if (run_start) begin
                phase    <= '0;
                samp_cnt <= '0;
                done     <= 1'b0;
                underrun <= 1'b0;
            end else begin
                if (due && fifo_empty) underrun <= 1'b1;
                if (step_go) begin
                    code_q     <= step_val;
                    dac_update <= 1'b1;
                    base_q     <= base_sel;
                    next_q     <= target_sel;
                    phase      <= final_step ? 3'd0 : phase + 3'd1;
                    if (pop) samp_cnt <= cnt_eff;
                    if (final_step && (mode_e == MODE_BURST) && (cnt_eff >= burst_len))
                        done <= 1'b1;
                end
            end
        end
    end

    assign dac_code = code_q;
endmodule

// File: rtl/dac_seq_chk.sv
// Property checker for dac_seq, bound into every instance of the top.
// Assumes the top's internal pop and run_start strobes are visible to the bind.
module dac_seq_chk #(
    parameter int W     = 12,
    parameter int DEPTH = 8,
    parameter int LW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    mode,
    input logic [W-1:0]  dac_code,
    input logic          dac_update,
    input logic          done,
    input logic          underrun,
    input logic          fifo_full,
    input logic          fifo_empty,
    input logic [LW-1:0] fifo_level,
    input logic          wr_en,
    input logic          pop,
    input logic          run_start
);
    // R4: the code only moves together with an update pulse.
    p_code_needs_update_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_code != $past(dac_code)) |-> dac_update);

    // R3: a write into a full FIFO with no pop leaves it full.
    p_full_write_dropped_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && wr_en && !pop) |=> fifo_full);

    // R3: occupancy never exceeds the depth.
    p_level_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= LW'(DEPTH));

    // R7: a finished burst gives no further updates.
    p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (mode == 2'd1) && !run_start) |=> !dac_update);

    // R7: done is raised only in burst mode.
    p_done_burst_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(mode) == 2'd1));

    // R9: underrun stays set until a new run starts.
    p_underrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !run_start) |=> underrun);

    // R9: underrun is raised only from an empty FIFO.
    p_underrun_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> $past(fifo_empty));
endmodule

bind dac_seq dac_seq_chk #(.W(W), .DEPTH(DEPTH), .LW(LW)) chk_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .dac_code(dac_code),
    .dac_update(dac_update), .done(done), .underrun(underrun),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .fifo_level(fifo_level),
    .wr_en(wr_en), .pop(pop), .run_start(run_start)
);

// File: tb/dac_seq_tb_top.sv
// Scoreboard bench for dac_seq: the driver queues expected codes, the
// monitor pops one per update pulse and checks step spacing.
module dac_seq_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_data = '0;
    logic [1:0]  mode = 2'd0;
    logic [11:0] static_code = '0;
    logic        run = 1'b0;
    logic [15:0] burst_len = '0;
    logic [15:0] rate_div = '0;
    logic [1:0]  interp_sel = '0;
    logic [11:0] dac_code;
    logic        dac_update;
    logic [3:0]  fifo_level;
    logic        fifo_empty, fifo_full, underrun, done;

    dac_seq dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .mode(mode), .static_code(static_code), .run(run),
        .burst_len(burst_len), .rate_div(rate_div), .interp_sel(interp_sel),
        .dac_code(dac_code), .dac_update(dac_update), .fifo_level(fifo_level),
        .fifo_empty(fifo_empty), .fifo_full(fifo_full),
        .underrun(underrun), .done(done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int          errors = 0;
    int          checks = 0;
    bit          finished = 0;
    logic [11:0] exp_q [$];
    int          model_prev = 0;
    int          cyc = 0;
    int          last_upd = 0;
    bit          have_prev = 0;
    bit          gap_on = 0;
    int          gap_exp = 1;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Monitor: compare each update with the queue head and check spacing.
    always @(negedge clk) begin
        cyc++;
        if (rst_n && dac_update) begin
            if (exp_q.size() == 0) begin
                check(0, "R4 unexpected update", int'(dac_code), -1);
            end else begin
                logic [11:0] e;
                e = exp_q.pop_front();
                check(dac_code == e, "R5/R6 code", int'(dac_code), int'(e));
            end
            if (gap_on && have_prev)
                check(cyc - last_upd == gap_exp, "R4 step spacing", cyc - last_upd, gap_exp);
            have_prev = 1;
            last_upd  = cyc;
        end
    end

    function automatic int floor_div(input int n, input int d);
        if (n >= 0) return n / d;
        return -((-n + d - 1) / d);
    endfunction

    // Queue the R steps one sample should produce (R6 formula).
    task automatic expect_sample(input int s, input int sel);
        int r;
        r = 1 << sel;
        for (int k = 1; k <= r; k++)
            exp_q.push_back(12'(model_prev + floor_div((s - model_prev) * k, r)));
        model_prev = s;
    endtask

    task automatic write_sample(input int v);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = 12'(v);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic drain();
        int n;
        n = 0;
        while (exp_q.size() != 0 && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check(exp_q.size() == 0, "R4 expected steps delivered", exp_q.size(), 0);
        repeat (12) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int val;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        check(dac_code == 0, "R1 code", dac_code, 0);
        check(!dac_update && !done && !underrun, "R1 flags", {dac_update, done, underrun}, 0);
        check(fifo_level == 0 && fifo_empty, "R1 fifo", fifo_level, 0);

        // R2: static level follows the input; an unchanged value gives no update.
        exp_q.push_back(12'h5A5);
        static_code = 12'h5A5;
        run = 1'b1;
        repeat (4) @(negedge clk);
        check(dac_code == 12'h5A5, "R2 static code", dac_code, 12'h5A5);
        run = 1'b0;
        static_code = 12'h5A5;
        repeat (4) @(negedge clk);
        exp_q.push_back(12'h123);
        static_code = 12'h123;
        repeat (4) @(negedge clk);
        check(dac_code == 12'h123 && exp_q.size() == 0, "R2 static change", dac_code, 12'h123);
        model_prev = 'h123;

        // R3: fill past the depth; the ninth write is dropped.
        for (int i = 0; i < 9; i++) begin
            val = (32'h100 + 32'h1C7 * i) & 32'hFFF;
            write_sample(val);
            if (i < 8) expect_sample(val, 0);
        end
        @(negedge clk);
        check(fifo_level == 8 && fifo_full, "R3 full at depth", fifo_level, 8);

        // R5/R4/R7: unscaled burst of 8, step every 3 clocks.
        mode = 2'd1; burst_len = 16'd8; interp_sel = 2'd0; rate_div = 16'd2;
        gap_exp = 3; gap_on = 1; have_prev = 0;
        @(negedge clk);
        run = 1'b1;
        drain();
        check(done == 1'b1, "R7 done after burst", done, 1);
        check(dac_code == 12'(model_prev), "R7 final code held", dac_code, model_prev);
        check(fifo_empty && fifo_level == 0, "R3 dropped write not stored", fifo_level, 0);
        check(underrun == 1'b0, "R9 no underrun with data", underrun, 0);
        run = 1'b0;

        // R6: 4:1 burst with rising, falling and full-scale samples, one step per clock.
        interp_sel = 2'd2; rate_div = 16'd0; burst_len = 16'd3;
        gap_exp = 1; have_prev = 0;
        write_sample('h100); expect_sample('h100, 2);
        write_sample('h0F3); expect_sample('h0F3, 2);
        write_sample('hFFF); expect_sample('hFFF, 2);
        @(negedge clk);
        run = 1'b1;
        drain();
        check(done == 1'b1, "R7 interpolated burst done", done, 1);
        check(dac_code == 12'hFFF, "R6 last step equals sample", dac_code, 'hFFF);
        run = 1'b0;

        // R8/R9: continuous 8:1, drain to underrun, then resume.
        mode = 2'd2; interp_sel = 2'd3; rate_div = 16'd1;
        gap_exp = 2; have_prev = 0;
        write_sample('h000); expect_sample('h000, 3);
        write_sample('h7F5); expect_sample('h7F5, 3);
        @(negedge clk);
        run = 1'b1;
        drain();
        check(underrun == 1'b1, "R9 underrun set", underrun, 1);
        check(done == 1'b0, "R8 continuous never done", done, 0);
        check(dac_code == 12'h7F5, "R9 code held on underrun", dac_code, 'h7F5);
        gap_on = 0;
        write_sample('h3A1); expect_sample('h3A1, 3);
        drain();
        check(underrun == 1'b1, "R9 underrun sticky", underrun, 1);
        check(dac_code == 12'h3A1, "R9 resume", dac_code, 'h3A1);

        // R10: run low pauses playback even with data stored.
        run = 1'b0;
        write_sample('h555);
        repeat (20) @(negedge clk);
        check(dac_code == 12'h3A1 && fifo_level == 1, "R10 paused", dac_code, 'h3A1);

        // R10: a new start clears underrun; 2:1 burst at one step per 4 clocks.
        mode = 2'd1; interp_sel = 2'd1; rate_div = 16'd3; burst_len = 16'd2;
        gap_on = 1; gap_exp = 4; have_prev = 0;
        expect_sample('h555, 1);
        write_sample('h0AA); expect_sample('h0AA, 1);
        @(negedge clk);
        run = 1'b1;
        repeat (2) @(negedge clk);
        check(underrun == 1'b0, "R10 start clears underrun", underrun, 1'b0);
        drain();
        check(done == 1'b1, "R7 2:1 burst done", done, 1);
        run = 1'b0;
        repeat (2) @(negedge clk);
        run = 1'b1;
        repeat (2) @(negedge clk);
        check(done == 1'b0, "R10 start clears done", done, 0);
        repeat (10) @(negedge clk);
        check(underrun == 1'b1 && dac_code == 12'h0AA, "R9 restart with empty fifo", underrun, 1);
        run = 1'b0;
        repeat (4) @(negedge clk);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule